// File: doc/BRIEF.md
# Lock Byte Guard

This block keeps an 8-bit protection byte for an on-chip programming interface. Each bit can only be programmed in one direction: a normal write can clear bits from 1 to 0 and nothing else. The only way back to the all-ones state is a chip-erase request. The two lowest bits select a memory protection level. Bits 2 to 5 hold two pairs of section-lock bits. Bits 6 and 7 are spare and always read as 1.

From the stored byte the block produces permission flags for the programming engine. There is one flag each for flash writes, EEPROM writes, memory readback, fuse writes and writes to the section-lock bits. Each flag is high when the operation is allowed. The engine raises a request pulse for an operation it wants to perform. If that operation is not allowed, the block answers with a one-cycle deny pulse.

Serial and parallel programming share the same rules. The mode input is accepted, but it does not change any permission.

Top module: `lock_guard`

## Requirements
- R1: After reset the byte reads 8'hFF, all five permission flags are high and the deny pulse is low.
- R2: An accepted lock write stores the old byte ANDed with the written value. A written 1 never sets a bit that is already 0.
- R3: Bit 0 and bit 1 form the protection level (bit 1 is the high bit). Bits 3:2 and 5:4 are the section-lock pairs. Bits 7:6 always read 1, whatever value is written.
- R4: A chip erase sets the byte to 8'hFF on the next clock edge. It wins over a lock write in the same cycle.
- R5: At level 2'b11, all five flags are high.
- R6: At level 2'b10, flash write, EEPROM write and fuse write are refused. Readback and section-lock writes stay allowed.
- R7: At level 2'b00, all five flags are low.
- R8: Level 2'b01 is not a defined level and is handled exactly like 2'b00.
- R9: While section-lock writes are refused, a lock write that would clear any of bits 5:2 is rejected as a whole. The byte stays unchanged and a deny pulse follows. A write that clears none of bits 5:2 is still accepted.
- R10: A flash-write, EEPROM-write, readback or fuse-write request whose flag is low produces a deny pulse. The pulse is high for exactly the one cycle after the request edge. Allowed requests produce no pulse.
- R11: The serial/parallel mode input has no effect on any permission flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeParallel | input | 1 | 1 = parallel programming, 0 = serial |
| lockWrReq | input | 1 | Lock write request (one cycle) |
| lockWrData | input | 8 | Value to AND into the lock byte |
| eraseReq | input | 1 | Chip-erase request |
| flashWrReq | input | 1 | Flash write request |
| eepWrReq | input | 1 | EEPROM write request |
| readReq | input | 1 | Memory readback request |
| fuseWrReq | input | 1 | Fuse write request |
| lockByte | output | 8 | Current lock byte |
| flashWrOk | output | 1 | Flash writes permitted |
| eepWrOk | output | 1 | EEPROM writes permitted |
| readOk | output | 1 | Readback permitted |
| fuseWrOk | output | 1 | Fuse writes permitted |
| bootLockWrOk | output | 1 | Section-lock bit writes permitted |
| denyPulse | output | 1 | One-cycle pulse after a refused request |

## Verification
A lock write or erase changes the byte on the clock edge that samples the request. The permission flags are decoded from the stored byte, so they change at that same edge. The deny pulse is registered, so it is high in the cycle after the request edge.

The driver applies each stimulus for exactly one cycle. For that edge it pushes the expected byte, flags and deny value into a queue. The monitor pops one entry per edge and compares it 1 ns after that edge, so the values it reads have settled from that edge only.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  localparam int LOCK_W    = 8;
  localparam int LVL_LO    = 0;
  localparam int LVL_W     = 2;
  localparam int SEC_LO    = 2;
  localparam int SEC_W     = 4;
  localparam int USED_W    = LVL_W + SEC_W;
  localparam int SPARE_W   = LOCK_W - USED_W;
  localparam int MODE_CNT  = 2;

  typedef struct packed {
    logic eraseAll;
    logic applyWrite;
  } lockStrobe_t;

  typedef struct packed {
    logic flashWr;
    logic eepWr;
    logic readBack;
    logic fuseWr;
    logic bootLockWr;
  } permit_t;
endpackage

// File: rtl/lock_guard_decode.sv
module lock_guard_decode
  import lock_guard_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic             modeParallel,
  output permit_t          perms
);
  permit_t permByMode [MODE_CNT];

  // Both programming modes follow the same table; one entry per mode.
  for (genvar m = 0; m < MODE_CNT; m++) begin : g_mode
    always_comb begin
      permByMode[m] = '0;
      unique case (level)
        2'b11: permByMode[m] = '{flashWr: 1'b1, eepWr: 1'b1, readBack: 1'b1,
                                 fuseWr: 1'b1, bootLockWr: 1'b1};
        2'b10: permByMode[m] = '{flashWr: 1'b0, eepWr: 1'b0, readBack: 1'b1,
                                 fuseWr: 1'b0, bootLockWr: 1'b1};
        default: permByMode[m] = '0;  // 2'b00 and undefined 2'b01 fail safe
      endcase
    end
  end

  assign perms = permByMode[modeParallel];
endmodule

// File: rtl/lock_guard_dp.sv
module lock_guard_dp
  import lock_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobe_t       strobe,
  input  logic [LOCK_W-1:0] wrData,
  output logic [LOCK_W-1:0] lockByte,
  output logic              secClearTry
);
  logic [LOCK_W-1:0] mask;
  logic [LOCK_W-1:0] stored;

  assign mask = {{SPARE_W{1'b1}}, wrData[USED_W-1:0]};
  assign secClearTry = |(stored[SEC_LO +: SEC_W] & ~wrData[SEC_LO +: SEC_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stored <= '1;
    else if (strobe.eraseAll)   stored <= '1;
    else if (strobe.applyWrite) stored <= stored & mask;
  end

  assign lockByte = stored;
endmodule

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lock_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockWrReq,
  input  logic        eraseReq,
  input  logic        secClearTry,
  input  logic        flashWrReq,
  input  logic        eepWrReq,
  input  logic        readReq,
  input  logic        fuseWrReq,
  input  permit_t     perms,
  output lockStrobe_t strobe,
  output logic        denyPulse
);
  logic wrRefused;
  logic accRefused;
  logic denyNext;

  assign wrRefused  = lockWrReq && !eraseReq && !perms.bootLockWr && secClearTry;
  assign accRefused = (flashWrReq && !perms.flashWr) || (eepWrReq && !perms.eepWr) ||
                      (readReq && !perms.readBack)   || (fuseWrReq && !perms.fuseWr);
  assign denyNext   = wrRefused || accRefused;

  always_comb begin
    strobe.eraseAll   = eraseReq;
    strobe.applyWrite = lockWrReq && !eraseReq && !wrRefused;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) denyPulse <= 1'b0;
    else       denyPulse <= denyNext;
  end
endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeParallel,
  input  logic              lockWrReq,
  input  logic [LOCK_W-1:0] lockWrData,
  input  logic              eraseReq,
  input  logic              flashWrReq,
  input  logic              eepWrReq,
  input  logic              readReq,
  input  logic              fuseWrReq,
  output logic [LOCK_W-1:0] lockByte,
  output logic              flashWrOk,
  output logic              eepWrOk,
  output logic              readOk,
  output logic              fuseWrOk,
  output logic              bootLockWrOk,
  output logic              denyPulse
);
  lockStrobe_t strobe;
  permit_t     perms;
  logic        secClearTry;

  lock_guard_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(lockWrData),
    .lockByte(lockByte), .secClearTry(secClearTry)
  );

  lock_guard_decode u_dec (
    .level(lockByte[LVL_LO +: LVL_W]), .modeParallel(modeParallel), .perms(perms)
  );

  lock_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lockWrReq(lockWrReq), .eraseReq(eraseReq),
    .secClearTry(secClearTry), .flashWrReq(flashWrReq), .eepWrReq(eepWrReq),
    .readReq(readReq), .fuseWrReq(fuseWrReq), .perms(perms),
    .strobe(strobe), .denyPulse(denyPulse)
  );

  assign flashWrOk    = perms.flashWr;
  assign eepWrOk      = perms.eepWr;
  assign readOk       = perms.readBack;
  assign fuseWrOk     = perms.fuseWr;
  assign bootLockWrOk = perms.bootLockWr;
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lockWrReq,
  input logic [7:0] lockWrData,
  input logic       eraseReq,
  input logic       flashWrReq,
  input logic [7:0] lockByte,
  input logic       flashWrOk,
  input logic       eepWrOk,
  input logic       readOk,
  input logic       fuseWrOk,
  input logic       bootLockWrOk,
  input logic       denyPulse
);
  logic [4:0] okVec;
  assign okVec = {flashWrOk, eepWrOk, readOk, fuseWrOk, bootLockWrOk};

  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    !eraseReq |=> ((lockByte & ~$past(lockByte)) == 8'h00));

  a_r4_erase_sets: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> (lockByte == 8'hFF));

  a_r3_spare_high: assert property (@(posedge clk) disable iff (!rstN)
    lockByte[7:6] == 2'b11);

  a_r6_partial: assert property (@(posedge clk) disable iff (!rstN)
    (lockByte[1:0] == 2'b10) |-> (okVec == 5'b00101));

  a_r7_closed: assert property (@(posedge clk) disable iff (!rstN)
    (lockByte[1:0] == 2'b00) |-> (okVec == 5'b00000));

  a_r8_undefined: assert property (@(posedge clk) disable iff (!rstN)
    (lockByte[1:0] == 2'b01) |-> (okVec == 5'b00000));

  a_r9_sec_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (lockWrReq && !eraseReq && !bootLockWrOk &&
     ((lockByte[5:2] & ~lockWrData[5:2]) != 4'h0)) |=> (denyPulse && $stable(lockByte)));

  a_r10_flash_deny: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrReq && !flashWrOk) |=> denyPulse);
endmodule

bind lock_guard lock_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .lockWrReq(lockWrReq), .lockWrData(lockWrData),
  .eraseReq(eraseReq), .flashWrReq(flashWrReq), .lockByte(lockByte),
  .flashWrOk(flashWrOk), .eepWrOk(eepWrOk), .readOk(readOk), .fuseWrOk(fuseWrOk),
  .bootLockWrOk(bootLockWrOk), .denyPulse(denyPulse)
);

// File: tb/lock_guard_tb.sv
module lock_guard_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeParallel = 1'b0, lockWrReq = 1'b0, eraseReq = 1'b0;
  logic flashWrReq = 1'b0, eepWrReq = 1'b0, readReq = 1'b0, fuseWrReq = 1'b0;
  logic [7:0] lockWrData = 8'hFF;
  logic [7:0] lockByte;
  logic flashWrOk, eepWrOk, readOk, fuseWrOk, bootLockWrOk, denyPulse;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] mLock = 8'hFF;

  logic [13:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  lock_guard u_dut (.*);

  // Permission table from the requirements: {flash, eep, read, fuse, secLock}
  function automatic logic [4:0] expOk(logic [7:0] b);
    case (b[1:0])
      2'b11:   return 5'b11111;
      2'b10:   return 5'b00101;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic step(input logic wr, input logic [7:0] d, input logic er,
                      input logic fr, input logic ewr, input logic rr,
                      input logic fu, input logic par, input string tag);
    logic [4:0] ok;
    logic deny;
    ok = expOk(mLock);
    deny = (fr && !ok[4]) || (ewr && !ok[3]) || (rr && !ok[2]) || (fu && !ok[1]);
    if (er) mLock = 8'hFF;
    else if (wr) begin
      if (!ok[0] && ((mLock[5:2] & ~d[5:2]) != 4'h0)) deny = 1'b1;
      else mLock = mLock & {2'b11, d[5:0]};
    end
    lockWrReq = wr; lockWrData = d; eraseReq = er; flashWrReq = fr;
    eepWrReq = ewr; readReq = rr; fuseWrReq = fu; modeParallel = par;
    expQ.push_back({mLock, expOk(mLock), deny});
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Monitor: one comparison per edge that has an expected entry
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [13:0] exp, act;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      act = {lockByte, flashWrOk, eepWrOk, readOk, fuseWrOk, bootLockWrOk, denyPulse};
      vectors++;
      if (act !== exp) begin
        miscompares++;
        $display("FAIL %s: got byte=%h ok=%b deny=%b, expected byte=%h ok=%b deny=%b",
                 tag, act[13:6], act[5:1], act[0], exp[13:6], exp[5:1], exp[0]);
      end
    end
  end

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked before release
    vectors++;
    if ({lockByte, flashWrOk, eepWrOk, readOk, fuseWrOk, bootLockWrOk, denyPulse} !== 14'h3FFE) begin
      miscompares++;
      $display("FAIL R1: got byte=%h deny=%b, expected byte=ff all ok deny=0", lockByte, denyPulse);
    end
    rstN = 1'b1;
    idle("R1 idle after reset");
    // R2/R3: ones ignored, spare bits stay 1
    step(1'b1, 8'hFF, 0, 0, 0, 0, 0, 0, "R2 all-ones write");
    step(1'b1, 8'h3F, 0, 0, 0, 0, 0, 0, "R3 spare bits written 0");
    step(1'b1, 8'hFB, 0, 0, 0, 0, 0, 0, "R2 clear section bit");
    step(1'b1, 8'hFF, 0, 0, 0, 0, 0, 0, "R2 cannot set back");
    step(1'b0, 8'hFF, 0, 1, 1, 1, 1, 0, "R5 open level requests");
    // R4: erase and erase-over-write
    step(1'b0, 8'hFF, 1, 0, 0, 0, 0, 0, "R4 erase");
    step(1'b1, 8'h00, 1, 0, 0, 0, 0, 0, "R4 erase wins");
    // R6 level 10
    step(1'b1, 8'hFE, 0, 0, 0, 0, 0, 0, "R6 enter level 10");
    step(1'b0, 8'hFF, 0, 1, 0, 0, 0, 0, "R10 flash deny");
    idle("R10 pulse one cycle");
    step(1'b0, 8'hFF, 0, 0, 0, 1, 0, 0, "R6 read allowed");
    step(1'b0, 8'hFF, 0, 0, 1, 0, 1, 1, "R11 parallel mode same");
    step(1'b1, 8'hF2, 0, 0, 0, 0, 0, 0, "R9 section write allowed at 10");
    // R8 undefined level
    step(1'b0, 8'hFF, 1, 0, 0, 0, 0, 0, "R4 erase again");
    step(1'b1, 8'hFD, 0, 0, 0, 0, 0, 1, "R8 enter level 01");
    step(1'b0, 8'hFF, 0, 0, 0, 1, 0, 0, "R8 read denied");
    // R7 level 00
    step(1'b1, 8'hFC, 0, 0, 0, 0, 0, 0, "R7 enter level 00");
    step(1'b0, 8'hFF, 0, 0, 0, 0, 1, 1, "R7 fuse denied");
    step(1'b1, 8'hF8, 0, 0, 0, 0, 0, 0, "R9 section clear refused");
    idle("R9 byte unchanged");
    step(1'b1, 8'h3C, 0, 0, 0, 0, 0, 0, "R9 write without section clear");
    step(1'b0, 8'hFF, 1, 0, 0, 0, 0, 0, "R4 erase restores");
    step(1'b0, 8'hFF, 0, 1, 1, 1, 1, 1, "R5 all allowed after erase");
    idle("final");
    @(negedge clk);
    finishRun();
  end
endmodule